// File: doc/BRIEF.md
# Trap and Interrupt Service Sequencer

This block is the control that a processor enters once an instruction has finished executing. It looks at a set of pending machine flags and picks the one with the highest rank. That flag is cleared and a trap sequence is started with the vector that belongs to its cause. When the trap sequence reports that it is done, the sequencer comes back and looks at the flags again. The cycle repeats until no flag is left. Only then does a pending bus interrupt request get a turn. That interrupt trap uses a vector supplied by the device. Afterwards the sequencer waits for the peripheral to let go of the bus and goes on to instruction fetch, without looking at the flags again.

A power clear puts the sequencer into a console-controlled rest state. A halt flag puts it into the same rest state. In that state it waits for the bus to be released passively. A release is seen when the busy, acknowledge, grant and slave-sync lines are all low. Such a release from the console clears the pending bus requests and starts a fetch.

The flag flip-flops sit outside the block. The block reports which flag to clear through a one-cycle clear pulse. A separate trap engine starts on a one-cycle start pulse and answers with a done strobe.

Top module: `svc_seq`

## Requirements
- R1: While `pwr_clr` is high, and afterwards until a release is seen, `rest_o` is 1 and `fetch_go_o`, `trap_go_o` and `flag_clr_o` stay 0. A release means `bus_busy`, `bus_sack`, `bus_grant` and `bus_ssyn` are all 0.
- R2: In rest, the clock edge that first samples a release produces, one cycle later, a single-cycle `fetch_go_o` together with a single-cycle `busreq_clr_o`. In that same cycle `rest_o` falls to 0.
- R3: `flags_i` bit positions, from highest rank (bit 0) to lowest (bit 10), and their vectors in octal are:
  - bit 0: halt (no vector)
  - bit 1: bus error, 04
  - bit 2: illegal instruction, 04
  - bit 3: reserved instruction, 10
  - bit 4: breakpoint, 14
  - bit 5: I/O trap, 20
  - bit 6: emulator trap, 30
  - bit 7: user trap, 34
  - bit 8: trace, 14
  - bit 9: stack overflow, 04
  - bit 10: power fail, 24
  
  The lowest set bit is serviced first, so among trap-instruction causes the lowest vector wins.
- R4: A set halt flag (bit 0) wins over all others. It gives a one-cycle `flag_clr_o` of 1 with no `trap_go_o`, and `rest_o` rises in that same cycle. The sequencer then behaves as in R1 and R2.
- R5: When a flag other than halt wins, `trap_go_o` is a one-cycle pulse with `trap_intr_o`=0. `trap_vec_o` carries the R3 vector, and `flag_clr_o` is one-hot on the winning bit in that same cycle.
- R6: After a flag trap, a `trap_done` strobe makes the sequencer decide again one cycle after the edge that samples it. It services the next pending flag, or fetches if nothing is pending.
- R7: When a decision sees no flag set and `br_req` high, it produces `trap_go_o` with `trap_intr_o`=1, `trap_vec_o`=`int_vec`, and `flag_clr_o`=0. A decision that sees a flag set never services the bus request.
- R8: After an interrupt trap's `trap_done`, no trap is started and flags and bus requests are not examined. The sequencer waits for a release and then gives `fetch_go_o` without `busreq_clr_o`.
- R9: A decision with no flag and no bus request gives `fetch_go_o` one cycle after the decision edge. The decision edge is the edge after the one that samples `svc_enter`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_clr | input | 1 | Asynchronous power clear, active high |
| svc_enter | input | 1 | Strobe: instruction execution finished |
| flags_i | input | 11 | Pending machine flags, bit layout per R3 |
| br_req | input | 1 | Bus interrupt request pending |
| int_vec | input | 8 | Vector supplied by the interrupting device |
| bus_busy | input | 1 | Bus busy line |
| bus_sack | input | 1 | Selection acknowledge line |
| bus_grant | input | 1 | Any bus grant line |
| bus_ssyn | input | 1 | Slave sync line |
| trap_done | input | 1 | Strobe: trap sequence finished |
| fetch_go_o | output | 1 | One-cycle pulse: go to instruction fetch |
| trap_go_o | output | 1 | One-cycle pulse: start a trap sequence |
| trap_intr_o | output | 1 | The started trap is a bus interrupt |
| trap_vec_o | output | 8 | Vector for the started trap |
| flag_clr_o | output | 11 | One-cycle clear for the serviced flag |
| busreq_clr_o | output | 1 | One-cycle clear of pending bus requests (console release) |
| rest_o | output | 1 | Resting under console control |

## Verification
The assertions check several properties on every cycle:
- A trap start lasts one cycle.
- A flag trap clears exactly one flag.
- An interrupt trap clears none.
- The priority pick grants exactly the lowest set flag.
- A fetch that leaves rest or the post-interrupt wait was preceded by a release.
- Nothing is started while resting.

Only the bench's scenarios show whether the chosen vector and rank are right for every cause and for every pair of causes. They also show that the sequencer comes back after a flag trap but not after an interrupt, that halt needs a real release, and that interrupts lose to any flag.

// File: rtl/svc_pkg.sv
package svc_pkg;
    localparam int NFLAG = 11;
    localparam int VEC_W = 8;
    localparam int IDX_W = $clog2(NFLAG);

    typedef enum logic [2:0] {
        S_REST  = 3'd0,
        S_IDLE  = 3'd1,
        S_DEC   = 3'd2,
        S_TRAPW = 3'd3,
        S_INTW  = 3'd4,
        S_RELW  = 3'd5
    } svc_state_e;

    typedef struct packed {
        svc_state_e              st;
        logic                    fetch;
        logic                    trap;
        logic                    intr;
        logic [VEC_W-1:0]        vec;
        logic [NFLAG-1:0]        clr;
        logic                    bclr;
    } svc_regs_t;

    // vector for each rank position (octal values)
    function automatic logic [VEC_W-1:0] cause_vec(input int idx);
        case (idx)
            1, 2, 9: cause_vec = VEC_W'(8'o04);
            3:       cause_vec = VEC_W'(8'o10);
            4, 8:    cause_vec = VEC_W'(8'o14);
            5:       cause_vec = VEC_W'(8'o20);
            6:       cause_vec = VEC_W'(8'o30);
            7:       cause_vec = VEC_W'(8'o34);
            10:      cause_vec = VEC_W'(8'o24);
            default: cause_vec = '0;
        endcase
    endfunction
endpackage

// File: rtl/svc_pick.sv
module svc_pick
    import svc_pkg::*;
#(
    parameter int N = NFLAG
) (
    input  logic [N-1:0]     flags,
    output logic             any,
    output logic [N-1:0]     grant,
    output logic [VEC_W-1:0] vec
);
    logic [VEC_W-1:0] vtab [N];

    generate
        for (genvar g = 0; g < N; g++) begin : g_vec
            assign vtab[g] = cause_vec(g);
        end
    endgenerate

    always_comb begin
        grant = '0;
        vec   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (flags[i]) begin
                grant = '0;
                grant[i] = 1'b1;
                vec = vtab[i];
            end
        end
        any = |flags;
    end
endmodule

// File: rtl/svc_release.sv
module svc_release (
    input  logic busy,
    input  logic sack,
    input  logic grant,
    input  logic ssyn,
    output logic released
);
    assign released = ~(busy | sack | grant | ssyn);
endmodule

// File: rtl/svc_seq.sv
module svc_seq
    import svc_pkg::*;
(
    input  logic             clk,
    input  logic             pwr_clr,
    input  logic             svc_enter,
    input  logic [NFLAG-1:0] flags_i,
    input  logic             br_req,
    input  logic [VEC_W-1:0] int_vec,
    input  logic             bus_busy,
    input  logic             bus_sack,
    input  logic             bus_grant,
    input  logic             bus_ssyn,
    input  logic             trap_done,
    output logic             fetch_go_o,
    output logic             trap_go_o,
    output logic             trap_intr_o,
    output logic [VEC_W-1:0] trap_vec_o,
    output logic [NFLAG-1:0] flag_clr_o,
    output logic             busreq_clr_o,
    output logic             rest_o
);
    localparam logic [NFLAG-1:0] HALT_BIT = NFLAG'(1);

    svc_regs_t r_d, r_q;
    logic             pick_any;
    logic [NFLAG-1:0] pick_grant;
    logic [VEC_W-1:0] pick_vec;
    logic             released;

    svc_pick #(.N(NFLAG)) u_pick (
        .flags (flags_i),
        .any   (pick_any),
        .grant (pick_grant),
        .vec   (pick_vec)
    );

    svc_release u_rel (
        .busy     (bus_busy),
        .sack     (bus_sack),
        .grant    (bus_grant),
        .ssyn     (bus_ssyn),
        .released (released)
    );

    always_comb begin
        r_d       = r_q;
        r_d.fetch = 1'b0;
        r_d.trap  = 1'b0;
        r_d.clr   = '0;
        r_d.bclr  = 1'b0;
        unique case (r_q.st)
            S_REST: begin
                if (released) begin
                    r_d.fetch = 1'b1;
                    r_d.bclr  = 1'b1;
                    r_d.st    = S_IDLE;
                end
            end
            S_IDLE: begin
                if (svc_enter) r_d.st = S_DEC;
            end
            S_DEC: begin
                if (pick_any) begin
                    r_d.clr = pick_grant;
                    if (pick_grant == HALT_BIT) begin
                        r_d.st = S_REST;
                    end else begin
                        r_d.trap = 1'b1;
                        r_d.intr = 1'b0;
                        r_d.vec  = pick_vec;
                        r_d.st   = S_TRAPW;
                    end
                end else if (br_req) begin
                    r_d.trap = 1'b1;
                    r_d.intr = 1'b1;
                    r_d.vec  = int_vec;
                    r_d.st   = S_INTW;
                end else begin
                    r_d.fetch = 1'b1;
                    r_d.st    = S_IDLE;
                end
            end
            S_TRAPW: begin
                if (trap_done) r_d.st = S_DEC;
            end
            S_INTW: begin
                if (trap_done) r_d.st = S_RELW;
            end
            S_RELW: begin
                if (released) begin
                    r_d.fetch = 1'b1;
                    r_d.st    = S_IDLE;
                end
            end
            default: r_d.st = S_REST;
        endcase
    end

    always_ff @(posedge clk or posedge pwr_clr) begin
        if (pwr_clr) begin
            r_q <= '{st: S_REST, fetch: 1'b0, trap: 1'b0, intr: 1'b0,
                     vec: '0, clr: '0, bclr: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign fetch_go_o   = r_q.fetch;
    assign trap_go_o    = r_q.trap;
    assign trap_intr_o  = r_q.intr;
    assign trap_vec_o   = r_q.vec;
    assign flag_clr_o   = r_q.clr;
    assign busreq_clr_o = r_q.bclr;
    assign rest_o       = (r_q.st == S_REST);

    // R3: the pick grants exactly one flag, the lowest set one
    a_r3_pick_lowest: assert property (@(posedge clk) disable iff (pwr_clr)
        pick_any |-> ($countones(pick_grant) == 1 &&
                      (flags_i & (pick_grant - NFLAG'(1))) == '0 &&
                      (flags_i & pick_grant) != '0));

    // R5: a trap start lasts one cycle
    a_r5_trap_pulse: assert property (@(posedge clk) disable iff (pwr_clr)
        trap_go_o |=> !trap_go_o);

    // R5: a flag trap clears exactly one flag
    a_r5_one_clear: assert property (@(posedge clk) disable iff (pwr_clr)
        (trap_go_o && !trap_intr_o) |-> $countones(flag_clr_o) == 1);

    // R7: an interrupt trap clears no flag
    a_r7_intr_noclr: assert property (@(posedge clk) disable iff (pwr_clr)
        (trap_go_o && trap_intr_o) |-> flag_clr_o == '0);

    // R1: nothing is started while resting
    a_r1_rest_quiet: assert property (@(posedge clk) disable iff (pwr_clr)
        rest_o |-> (!trap_go_o && !fetch_go_o));

    // R2: leaving rest follows a sampled release
    a_r2_rest_release: assert property (@(posedge clk) disable iff (pwr_clr)
        (fetch_go_o && $past(rest_o)) |-> $past(released));

    // R8: leaving the post-interrupt wait follows a sampled release
    a_r8_relw_release: assert property (@(posedge clk) disable iff (pwr_clr)
        (fetch_go_o && $past(r_q.st == S_RELW)) |-> ($past(released) && !busreq_clr_o));
endmodule

// File: tb/svc_seq_bench.sv
module svc_seq_bench;
    localparam int NF = 11;

    logic          clk = 1'b0;
    logic          pwr_clr = 1'b1;
    logic          svc_enter = 1'b0;
    logic [NF-1:0] flg = '0;
    logic [NF-1:0] flg_set = '0;
    logic          br_req = 1'b0;
    logic [7:0]    int_vec = 8'h00;
    logic          bus_busy = 1'b1;
    logic          bus_sack = 1'b0;
    logic          bus_grant = 1'b0;
    logic          bus_ssyn = 1'b0;
    logic          trap_done = 1'b0;
    logic          fetch_go_o, trap_go_o, trap_intr_o, busreq_clr_o, rest_o;
    logic [7:0]    trap_vec_o;
    logic [NF-1:0] flag_clr_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // ev_*: values captured at the first event seen by wait_ev
    logic          ev_got, ev_fetch, ev_trap, ev_intr, ev_bclr, ev_rest;
    logic [7:0]    ev_vec;
    logic [NF-1:0] ev_clr;

    always #10 clk = ~clk;

    svc_seq u_svc_seq (
        .clk(clk), .pwr_clr(pwr_clr), .svc_enter(svc_enter), .flags_i(flg),
        .br_req(br_req), .int_vec(int_vec), .bus_busy(bus_busy),
        .bus_sack(bus_sack), .bus_grant(bus_grant), .bus_ssyn(bus_ssyn),
        .trap_done(trap_done), .fetch_go_o(fetch_go_o), .trap_go_o(trap_go_o),
        .trap_intr_o(trap_intr_o), .trap_vec_o(trap_vec_o),
        .flag_clr_o(flag_clr_o), .busreq_clr_o(busreq_clr_o), .rest_o(rest_o)
    );

    // external flag flip-flops
    always @(posedge clk) flg <= (flg | flg_set) & ~flag_clr_o;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic [7:0] exp_vec(input int i);
        case (i)
            1: return 8'd4;   2: return 8'd4;   3: return 8'd8;
            4: return 8'd12;  5: return 8'd16;  6: return 8'd24;
            7: return 8'd28;  8: return 8'd12;  9: return 8'd4;
            10: return 8'd20;
            default: return 8'd0;
        endcase
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // wait for the next output event, sampling just after each edge
    task automatic wait_ev(input int lim);
        ev_got = 1'b0;
        for (int k = 0; k < lim && !ev_got; k++) begin
            @(posedge clk); #1;
            if (fetch_go_o || trap_go_o || (|flag_clr_o)) begin
                ev_got = 1'b1;
                ev_fetch = fetch_go_o; ev_trap = trap_go_o; ev_intr = trap_intr_o;
                ev_vec = trap_vec_o; ev_clr = flag_clr_o; ev_bclr = busreq_clr_o;
                ev_rest = rest_o;
            end
        end
    endtask

    task automatic set_flags(input logic [NF-1:0] m);
        @(negedge clk) flg_set = m;
        @(negedge clk) flg_set = '0;
    endtask

    task automatic enter_svc();
        @(negedge clk) svc_enter = 1'b1;
        @(negedge clk) svc_enter = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk) trap_done = 1'b1;
        @(negedge clk) trap_done = 1'b0;
    endtask

    task automatic expect_trap(input int i, input string tag);
        wait_ev(8);
        check(ev_got && ev_trap && !ev_intr, tag, int'(ev_trap), 1);
        check(ev_vec == exp_vec(i), tag, int'(ev_vec), int'(exp_vec(i)));
        check(ev_clr == (NF'(1) << i), tag, int'(ev_clr), int'(NF'(1) << i));
    endtask

    task automatic expect_fetch(input string tag);
        wait_ev(8);
        check(ev_got && ev_fetch && !ev_trap, tag, int'(ev_fetch), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check(rest_o == 1'b1, "R1 rest during clear", int'(rest_o), 1);
        check(!fetch_go_o && !trap_go_o && flag_clr_o == '0, "R1 quiet", int'(trap_go_o), 0);
        @(negedge clk) pwr_clr = 1'b0;
        // R1: each line alone holds the rest state
        for (int l = 0; l < 4; l++) begin
            @(negedge clk);
            {bus_busy, bus_sack, bus_grant, bus_ssyn} = 4'b1000 >> l;
            wait_ev(4);
            check(!ev_got && rest_o, "R1 holds while line high", int'(ev_got), 0);
        end
        // R2: console release
        @(negedge clk) {bus_busy, bus_sack, bus_grant, bus_ssyn} = 4'b0000;
        @(posedge clk); #1;
        check(fetch_go_o && busreq_clr_o && !rest_o, "R2 release fetch",
              int'({fetch_go_o, busreq_clr_o, rest_o}), 6);
        @(posedge clk); #1;
        check(!fetch_go_o && !busreq_clr_o, "R2 single pulse", int'(fetch_go_o), 0);

        // R9: no flags no requests; fetch exactly two edges after the strobe edge
        @(negedge clk) svc_enter = 1'b1;
        @(negedge clk) svc_enter = 1'b0;
        @(posedge clk); #1;
        check(fetch_go_o == 1'b1, "R9 fetch timing", int'(fetch_go_o), 1);

        // R3 R5 R6: each flag alone
        for (int i = 1; i < NF; i++) begin
            set_flags(NF'(1) << i);
            enter_svc();
            expect_trap(i, "R5 single flag");
            pulse_done();
            expect_fetch("R6 back to fetch");
        end

        // R3 R6: every pair of non-halt flags, lower bit first
        for (int i = 1; i < NF; i++) begin
            for (int j = i + 1; j < NF; j++) begin
                set_flags((NF'(1) << i) | (NF'(1) << j));
                enter_svc();
                expect_trap(i, "R3 pair first");
                pulse_done();
                expect_trap(j, "R6 pair second");
                pulse_done();
                expect_fetch("R6 pair fetch");
            end
        end

        // R4: halt wins, rests until release
        @(negedge clk) bus_busy = 1'b1;
        set_flags(NF'(1) | (NF'(1) << 5));
        enter_svc();
        wait_ev(8);
        check(ev_got && !ev_trap && ev_clr == NF'(1) && ev_rest, "R4 halt",
              int'(ev_clr), 1);
        wait_ev(4);
        check(!ev_got && rest_o, "R4 rest holds", int'(ev_got), 0);
        @(negedge clk) bus_busy = 1'b0;
        wait_ev(4);
        check(ev_fetch && ev_bclr, "R2 release after halt", int'(ev_bclr), 1);
        enter_svc();
        expect_trap(5, "R4 remaining flag");
        pulse_done();
        expect_fetch("R6 after halt");

        // R7: interrupt with no flags
        @(negedge clk) begin br_req = 1'b1; int_vec = 8'o140; bus_busy = 1'b1; end
        enter_svc();
        wait_ev(8);
        check(ev_trap && ev_intr && ev_vec == 8'o140 && ev_clr == '0, "R7 intr",
              int'(ev_vec), 96);
        // R8: flag set meanwhile is not examined
        set_flags(NF'(1) << 3);
        @(negedge clk) br_req = 1'b0;
        pulse_done();
        wait_ev(5);
        check(!ev_got, "R8 waits for release", int'(ev_got), 0);
        @(negedge clk) bus_busy = 1'b0;
        wait_ev(4);
        check(ev_fetch && !ev_trap && !ev_bclr, "R8 fetch no clear", int'(ev_trap), 0);
        enter_svc();
        expect_trap(3, "R8 flag kept");
        pulse_done();
        expect_fetch("R6 after R8");

        // R7: flags beat interrupt, interrupt follows after re-entry
        @(negedge clk) begin br_req = 1'b1; int_vec = 8'o200; end
        set_flags(NF'(1) << 9);
        enter_svc();
        expect_trap(9, "R7 flag before intr");
        pulse_done();
        wait_ev(8);
        check(ev_trap && ev_intr && ev_vec == 8'o200, "R7 intr after flags",
              int'(ev_vec), 128);
        @(negedge clk) br_req = 1'b0;
        pulse_done();
        expect_fetch("R8 fetch after intr");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule